// File: doc/BRIEF.md
# Flag-Driven Branch Resolver

This block resolves conditional branches for a short fetch/decode/execute pipeline that keeps no condition-code register. While a branch sits in decode, it tests the zero, negative, carry and overflow flags that the add or subtract in execute is producing in that same cycle. It also takes jump requests from execute. When either one redirects the pipeline, the block issues a one-cycle redirect with its target and then annuls the two instructions behind it.

A branch word has a 4-bit opcode in bits 15:12, where the value 0xB marks a branch. It has a 4-bit condition code in bits 11:8 and a signed 8-bit displacement in bits 7:0. The decode PC given with the word is the branch address plus 2. The target is that PC plus twice the sign-extended displacement. The annul output qualifies whatever instruction is in decode. While annul is high, the rest of the pipeline must suppress that instruction's register write and memory access, and this block will not let it branch.

Top module: `branch_decider`

## Requirements
- R1: During and immediately after synchronous reset, `redirect` and `annul` are 0 and `redirect_pc` is 0.
- R2: A decode word whose bits 15:12 are not 0xB never causes a redirect, whatever its other bits and the flags are.
- R3: For a valid, non-annulled word with bits 15:12 = 0xB, the condition code in bits 11:8 is evaluated on the flags presented in the same cycle. The codes are: 0 always, 1 never, 2 Z, 3 not Z, 4 C, 5 not C, 6 V, 7 not V, 8 N xor V, 9 its inverse, 10 (N xor V) or Z, 11 its inverse, 12 not C, 13 C, 14 (not C) or Z, 15 C and not Z.
- R4: The branch target is `dc_pc` + 2 × sign-extended bits 7:0, taken modulo 2^16. `redirect_pc` holds its last value while no redirect occurs.
- R5: A redirect appears as a single-cycle `redirect` pulse, with its `redirect_pc`, in the cycle after the branch or jump is presented.
- R6: `ex_jump` redirects to `ex_jump_target` one cycle later. If a branch is in decode in the same cycle, the jump takes priority and the branch is ignored.
- R7: After every redirect, `annul` is high from the redirect cycle until two cycles with `dc_valid` = 1 have passed. Cycles with `dc_valid` = 0 do not use up an annul slot.
- R8: A branch presented while `annul` is high never redirects, even when its condition is true.
- R9: Flags are not stored. Flag values presented in earlier cycles have no effect on a branch.
- R10: A redirect that occurs while annul slots remain reloads the count to two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dc_valid | input | 1 | A word is present in decode |
| dc_insn | input | 16 | Decode instruction word |
| dc_pc | input | 16 | Branch address plus 2 |
| flag_z | input | 1 | Zero flag from the execute-stage add/subtract |
| flag_n | input | 1 | Negative flag from the execute-stage add/subtract |
| flag_c | input | 1 | Carry (no-borrow) flag from the execute-stage add/subtract |
| flag_v | input | 1 | Overflow flag from the execute-stage add/subtract |
| ex_jump | input | 1 | A jump in execute is redirecting |
| ex_jump_target | input | 16 | Jump destination |
| redirect | output | 1 | Registered redirect pulse |
| redirect_pc | output | 16 | Registered redirect target |
| annul | output | 1 | Instruction now in decode is squashed |

## Verification
`redirect`, `redirect_pc` and the new value of `annul` are each due exactly one clock edge after the stimulus that causes them. The driver tags every expected item with that cycle number. The monitor compares each item only at the falling edge of the cycle it is due, so it never reads an output in the middle of an update. The annul window is traced through a count model held in the bench, so the checks also cover shadows stretched by decode bubbles and shadows reloaded by a second redirect.

// File: rtl/bdu_pkg.sv
package bdu_pkg;
  localparam int COND_W   = 4;
  localparam int NUM_COND = 1 << COND_W;
  localparam int NUM_BASE = NUM_COND / 2;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/bdu_cond_eval.sv
module bdu_cond_eval
  import bdu_pkg::*;
(
  input  flags_t            flg,
  input  logic [COND_W-1:0] code,
  output logic              hit
);
  logic [NUM_BASE-1:0] base;
  logic [NUM_COND-1:0] all_cc;
  logic                lt_s;

  assign lt_s    = flg.n ^ flg.v;
  assign base[0] = 1'b1;
  assign base[1] = flg.z;
  assign base[2] = flg.c;
  assign base[3] = flg.v;
  assign base[4] = lt_s;
  assign base[5] = lt_s | flg.z;
  assign base[6] = ~flg.c;
  assign base[7] = ~flg.c | flg.z;

  // each odd code is the complement of the even code below it
  for (genvar k = 0; k < NUM_BASE; k++) begin : g_pair
    assign all_cc[2*k]   = base[k];
    assign all_cc[2*k+1] = ~base[k];
  end

  assign hit = all_cc[code];
endmodule

// File: rtl/bdu_target.sv
module bdu_target #(
  parameter int XLEN   = 16,
  parameter int DISP_W = 8
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   target
);
  localparam int EXT_W = XLEN - DISP_W;
  logic [XLEN-1:0] ext;

  assign ext    = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign target = pc + (ext << 1);
endmodule

// File: rtl/bdu_shadow.sv
module bdu_shadow #(
  parameter int SLOTS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  output logic busy
);
  localparam int CW = $clog2(SLOTS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= CW'(SLOTS);
    else if (step && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != 0);

  // R7: a bubble in decode does not consume an annul slot
  assert_bubble_keeps_annul_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !step) |=> busy);
  // R10: a redirect always opens a fresh window
  assert_load_opens_window_R10: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
endmodule

// File: rtl/branch_decider.sv
module branch_decider
  import bdu_pkg::*;
#(
  parameter int          XLEN   = 16,
  parameter int          DISP_W = 8,
  parameter int          OPC_W  = 4,
  parameter logic [3:0]  OPC_BR = 4'hB,
  parameter int          SHADOW = 2,
  localparam int         INSN_W = OPC_W + COND_W + DISP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dc_valid,
  input  logic [INSN_W-1:0] dc_insn,
  input  logic [XLEN-1:0]   dc_pc,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              flag_c,
  input  logic              flag_v,
  input  logic              ex_jump,
  input  logic [XLEN-1:0]   ex_jump_target,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              annul
);
  logic [OPC_W-1:0]  opc;
  logic [COND_W-1:0] code;
  logic [DISP_W-1:0] disp;
  flags_t            flg;
  logic              cond_hit;
  logic [XLEN-1:0]   br_target;
  logic              br_fire;
  logic              evt;
  logic [XLEN-1:0]   next_pc;

  assign opc  = dc_insn[INSN_W-1 -: OPC_W];
  assign code = dc_insn[DISP_W +: COND_W];
  assign disp = dc_insn[DISP_W-1:0];
  assign flg  = '{z: flag_z, n: flag_n, c: flag_c, v: flag_v};

  bdu_cond_eval u_cond (
    .flg  (flg),
    .code (code),
    .hit  (cond_hit)
  );

  bdu_target #(.XLEN(XLEN), .DISP_W(DISP_W)) u_tgt (
    .pc     (dc_pc),
    .disp   (disp),
    .target (br_target)
  );

  assign br_fire = dc_valid && !annul && (opc == OPC_W'(OPC_BR)) && cond_hit;
  assign evt     = ex_jump || br_fire;
  assign next_pc = ex_jump ? ex_jump_target : br_target;

  bdu_shadow #(.SLOTS(SHADOW)) u_shadow (
    .clk  (clk),
    .rst  (rst),
    .load (evt),
    .step (dc_valid),
    .busy (annul)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
    end else begin
      redirect <= evt;
      if (evt) redirect_pc <= next_pc;
    end
  end

  // R7: every redirect is accompanied by an open annul window
  assert_redirect_annuls_R7: assert property (@(posedge clk) disable iff (rst)
    redirect |-> annul);
  // R8: a squashed branch cannot redirect
  assert_annulled_no_branch_R8: assert property (@(posedge clk) disable iff (rst)
    (annul && dc_valid && !ex_jump) |=> !redirect);
  // R6: a jump redirects to its own target
  assert_jump_target_R6: assert property (@(posedge clk) disable iff (rst)
    ex_jump |=> (redirect && redirect_pc == $past(ex_jump_target)));
  // R3: the always code fires
  assert_always_taken_R3: assert property (@(posedge clk) disable iff (rst)
    (dc_valid && !annul && !ex_jump && opc == OPC_W'(OPC_BR) && code == '0) |=> redirect);
  // R2: other opcodes never branch
  assert_non_branch_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!ex_jump && opc != OPC_W'(OPC_BR)) |=> !redirect);
endmodule

// File: tb/branch_decider_bench.sv
module branch_decider_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dc_valid = 1'b0;
  logic [15:0] dc_insn = '0;
  logic [15:0] dc_pc = '0;
  logic        flag_z = 1'b0, flag_n = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
  logic        ex_jump = 1'b0;
  logic [15:0] ex_jump_target = '0;
  logic        redirect;
  logic [15:0] redirect_pc;
  logic        annul;

  always #10 clk = ~clk;

  branch_decider u_branch_decider (
    .clk(clk), .rst(rst), .dc_valid(dc_valid), .dc_insn(dc_insn), .dc_pc(dc_pc),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
    .ex_jump(ex_jump), .ex_jump_target(ex_jump_target),
    .redirect(redirect), .redirect_pc(redirect_pc), .annul(annul)
  );

  typedef struct {
    int          due;
    logic        red;
    logic [15:0] pc;
    logic        ann;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t it;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  int   m_cnt = 0;
  logic [15:0] m_pc = '0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic condf(input logic [3:0] c, input logic z, n, cf, v);
    case (c)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return z;
      4'd3:  return !z;
      4'd4:  return cf;
      4'd5:  return !cf;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return n != v;
      4'd9:  return n == v;
      4'd10: return (n != v) || z;
      4'd11: return (n == v) && !z;
      4'd12: return !cf;
      4'd13: return cf;
      4'd14: return !cf || z;
      default: return cf && !z;
    endcase
  endfunction

  task automatic step(input logic v, input logic [15:0] insn, input logic [15:0] pc,
                      input logic [3:0] f, input logic j, input logic [15:0] jt,
                      input string req);
    logic hit, evt;
    logic [15:0] tgt;
    exp_t e;
    @(posedge clk); #1;
    dc_valid = v; dc_insn = insn; dc_pc = pc;
    {flag_z, flag_n, flag_c, flag_v} = f;
    ex_jump = j; ex_jump_target = jt;
    hit = v && (m_cnt == 0) && (insn[15:12] == 4'hB) &&
          condf(insn[11:8], f[3], f[2], f[1], f[0]);
    evt = j || hit;
    tgt = j ? jt : pc + {{7{insn[7]}}, insn[7:0], 1'b0};
    if (evt) m_cnt = 2;
    else if (v && m_cnt != 0) m_cnt = m_cnt - 1;
    if (evt) m_pc = tgt;
    e.due = cyc + 1; e.red = evt; e.pc = m_pc; e.ann = (m_cnt != 0); e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 16'h0, 4'h0, 1'b0, 16'h0, "R7");
  endtask

  task automatic nops(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, 16'h1234, 16'h0, 4'hF, 1'b0, 16'h0, req);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      it = q.pop_front();
      checks++;
      if (redirect !== it.red || redirect_pc !== it.pc || annul !== it.ann) begin
        errors++;
        $display("FAIL %s cycle %0d: redirect/pc/annul = %b/%h/%b expected %b/%h/%b",
                 it.req, cyc, redirect, redirect_pc, annul, it.red, it.pc, it.ann);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (redirect !== 1'b0 || annul !== 1'b0 || redirect_pc !== 16'h0) begin
      errors++;
      $display("FAIL R1: redirect/pc/annul = %b/%h/%b expected 0/0000/0",
               redirect, redirect_pc, annul);
    end
    @(posedge clk); #1 rst = 1'b0;
    idle(2);

    // R3 and R7: every code against every flag pattern
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        step(1'b1, {4'hB, 4'(c), 8'h05}, 16'h1000 + 16'(c * 32 + f * 2), 4'(f),
             1'b0, 16'h0, "R3");
        if (m_cnt != 0) nops(2, "R7");
      end
    end

    // R4: displacement extremes and wrap
    step(1'b1, 16'hB07F, 16'h2000, 4'h0, 1'b0, 16'h0, "R4"); nops(2, "R4");
    step(1'b1, 16'hB080, 16'h2000, 4'h0, 1'b0, 16'h0, "R4"); nops(2, "R4");
    step(1'b1, 16'hB010, 16'hFFF0, 4'h0, 1'b0, 16'h0, "R4"); nops(2, "R4");
    step(1'b1, 16'hB000, 16'h3002, 4'h0, 1'b0, 16'h0, "R4"); nops(3, "R4");

    // R7: bubbles stretch the shadow
    step(1'b1, 16'hB002, 16'h4000, 4'h0, 1'b0, 16'h0, "R7");
    idle(2); nops(3, "R7");

    // R8: branches in the shadow are squashed
    step(1'b1, 16'hB004, 16'h5000, 4'h0, 1'b0, 16'h0, "R8");
    step(1'b1, 16'hB040, 16'h5100, 4'h0, 1'b0, 16'h0, "R8");
    step(1'b1, 16'hB041, 16'h5200, 4'h0, 1'b0, 16'h0, "R8");
    step(1'b1, 16'hB042, 16'h5300, 4'h0, 1'b0, 16'h0, "R8"); nops(2, "R8");

    // R2: other opcodes never branch
    for (int o = 0; o < 16; o++)
      if (o != 11) step(1'b1, {4'(o), 4'h0, 8'h10}, 16'h6000, 4'h0, 1'b0, 16'h0, "R2");

    // R9: earlier flags are not retained
    step(1'b1, 16'h0000, 16'h7000, 4'h8, 1'b0, 16'h0, "R9");
    step(1'b1, 16'hB220, 16'h7002, 4'h0, 1'b0, 16'h0, "R9");
    step(1'b1, 16'hB220, 16'h7004, 4'h8, 1'b0, 16'h0, "R9"); nops(2, "R9");

    // R6: jump beats a branch in the same cycle
    step(1'b1, 16'hB010, 16'h8000, 4'h0, 1'b1, 16'h4444, "R6"); nops(2, "R6");
    step(1'b0, 16'h0000, 16'h0, 4'h0, 1'b1, 16'h9998, "R6"); nops(2, "R6");

    // R10: a jump inside the shadow reloads the window
    step(1'b1, 16'hB006, 16'hA000, 4'h0, 1'b0, 16'h0, "R10");
    step(1'b1, 16'h1111, 16'h0, 4'h0, 1'b1, 16'hABC0, "R10");
    nops(3, "R10");
    step(1'b1, 16'hB0FF, 16'hC000, 4'h0, 1'b0, 16'h0, "R5"); nops(2, "R5");

    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule